// File: doc/BRIEF.md
# Indirect Register Access Sequencer

This block is a bus master on the host side. It turns one register read or write request into a short sequence of strobes on a 16-bit peripheral bus. That bus has only two ports: an address port and a data port. The `bus_a0` line selects between them.

Each sequence starts with a write of an index byte to the address port. Bit 7 of that byte gives the direction and the lower seven bits give the register number. One or two data-port transfers follow. Register numbers below `WIDE_LIMIT` are 32 bits wide and move as two halfwords, low half first. Higher numbers are 16 bits wide and move as one halfword.

The peripheral needs fixed minimum idle times between strobes. One applies after the address access and a shorter one applies between data accesses. The block converts these times into clock cycles at elaboration, rounding up, and holds every strobe inactive for the whole gap. A request is taken with `req` while `ready` is high. A one-cycle `done` pulse marks completion, and for reads it comes with the assembled data on `rdata`.

Top module: `regbus_seq`

## Requirements
- R1: Each accepted request produces exactly one address-port strobe (`bus_a0`=0). It is a write strobe (`bus_wr_n` low, `bus_rd_n` high), and it is the first strobe of the sequence.
- R2: The index byte driven on `bus_dout[7:0]` during the address strobe is `{write, index[6:0]}`. Bit 7 is 1 for a write and 0 for a read.
- R3: A register number below `WIDE_LIMIT` (default 0x20) gets two data-port strobes. A number at or above it gets exactly one.
- R4: On a write, the data strobes drive `wdata[15:0]` first and then `wdata[31:16]` (wide registers only). Both use `bus_wr_n`.
- R5: On a read, the data strobes use `bus_rd_n`. The first returned halfword lands in `rdata[15:0]` and the second in `rdata[31:16]`. For a 16-bit register `rdata[31:16]` is zero.
- R6: Between the end of the address strobe and the start of the first data strobe, all strobes stay inactive for exactly ceil(`ADDR_GAP_PS`/`CLK_PS`) cycles (60 by default).
- R7: After every data strobe, all strobes stay inactive for exactly ceil(`DATA_GAP_PS`/`CLK_PS`) cycles (30 by default). This holds before the next data strobe and before the sequence ends.
- R8: Every strobe is active for exactly `STROBE_CYC` cycles. `bus_rd_n` and `bus_wr_n` are never low together, and `bus_a0` and `bus_dout` do not change while a strobe is active.
- R9: `bus_cs_n` is low for the whole sequence, including every gap, and high while idle.
- R10: `ready` is high only while idle. A `req` seen while busy is ignored, and changes to `index`, `write` or `wdata` after acceptance do not affect the bus.
- R11: `done` is a single-cycle pulse and `ready` rises in the same cycle. Counted from the accepting edge, this happens 2·S+A+D cycles later for a 16-bit register and 3·S+A+2·D for a 32-bit one (S strobe, A address gap, D data gap).
- R12: After reset `ready`=1, `done`=0, and `bus_cs_n`, `bus_rd_n`, `bus_wr_n` are all high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request; accepted when `ready` is high |
| ready | output | 1 | Sequencer idle and able to accept |
| index | input | 7 | Register number |
| write | input | 1 | 1 for write, 0 for read |
| wdata | input | 32 | Write data; only the low half is used for 16-bit registers |
| rdata | output | 32 | Read data, valid with `done` |
| done | output | 1 | One-cycle completion pulse |
| bus_cs_n | output | 1 | Peripheral chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_a0 | output | 1 | Port select: 0 address, 1 data |
| bus_dout | output | 16 | Data driven toward the peripheral |
| bus_doe | output | 1 | High while the block drives `bus_dout` |
| bus_din | input | 16 | Data returned by the peripheral |

## Verification
The bench targets the width boundary at register numbers 0x1F and 0x20. A wrong compare there would issue one halfword too many or too few, which shows up both in the data-strobe count and in the end-of-sequence cycle. Each gap is measured in cycles. A design that reuses the short data gap after the address access, or drops the trailing gap, would miss the exact count or the exact latency. Swapped halfwords, or stale upper read bits left after a wide read, are caught by alternating wide and narrow reads with distinct returned values. A request held high, with changed inputs, while the block is busy must leave the bus pattern of the accepted request unchanged.

// File: rtl/regbus_seq.sv
module regbus_seq #(
  parameter int CLK_PS      = 5000,
  parameter int ADDR_GAP_PS = 300000,
  parameter int DATA_GAP_PS = 150000,
  parameter int STROBE_CYC  = 2,
  parameter int WIDE_LIMIT  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  output logic        ready,
  input  logic [6:0]  index,
  input  logic        write,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        done,
  output logic        bus_cs_n,
  output logic        bus_rd_n,
  output logic        bus_wr_n,
  output logic        bus_a0,
  output logic [15:0] bus_dout,
  output logic        bus_doe,
  input  logic [15:0] bus_din
);
  localparam int A_CYC  = (ADDR_GAP_PS + CLK_PS - 1) / CLK_PS;
  localparam int D_CYC  = (DATA_GAP_PS + CLK_PS - 1) / CLK_PS;
  localparam int M1     = (A_CYC > D_CYC) ? A_CYC : D_CYC;
  localparam int MAXC   = (M1 > STROBE_CYC) ? M1 : STROBE_CYC;
  localparam int CNT_W  = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] S_LD = CNT_W'(STROBE_CYC - 1);
  localparam logic [CNT_W-1:0] A_LD = CNT_W'(A_CYC - 1);
  localparam logic [CNT_W-1:0] D_LD = CNT_W'(D_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_STRB, S_GAP} st_t;

  st_t             st;
  logic [1:0]      phase;
  logic [CNT_W-1:0] cnt;
  logic            wr_r, wide_r;
  logic [6:0]      idx_r;
  logic [31:0]     wd_r;

  wire last    = (phase == 2'd2) || (phase == 2'd1 && !wide_r);
  wire dphase  = (phase != 2'd0);
  wire drives  = !dphase || wr_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      phase  <= 2'd0;
      cnt    <= '0;
      wr_r   <= 1'b0;
      wide_r <= 1'b0;
      idx_r  <= '0;
      wd_r   <= '0;
      rdata  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          st     <= S_STRB;
          phase  <= 2'd0;
          cnt    <= S_LD;
          wr_r   <= write;
          wide_r <= (32'(index) < WIDE_LIMIT);
          idx_r  <= index;
          wd_r   <= wdata;
          if (!write) rdata <= '0;
        end
        S_STRB: if (cnt == '0) begin
          st  <= S_GAP;
          cnt <= dphase ? D_LD : A_LD;
          if (dphase && !wr_r) begin
            if (phase == 2'd1) rdata[15:0]  <= bus_din;
            else               rdata[31:16] <= bus_din;
          end
        end else cnt <= cnt - 1'b1;
        S_GAP: if (cnt == '0) begin
          if (last) begin
            st    <= S_IDLE;
            phase <= 2'd0;
            done  <= 1'b1;
          end else begin
            st    <= S_STRB;
            phase <= phase + 2'd1;
            cnt   <= S_LD;
          end
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ready    = (st == S_IDLE);
  assign bus_cs_n = (st == S_IDLE);
  assign bus_wr_n = !((st == S_STRB) && drives);
  assign bus_rd_n = !((st == S_STRB) && !drives);
  assign bus_a0   = dphase;
  assign bus_doe  = (st != S_IDLE) && drives;
  assign bus_dout = (phase == 2'd0) ? {8'h00, wr_r, idx_r} :
                    (phase == 2'd1) ? wd_r[15:0] : wd_r[31:16];
endmodule

module regbus_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ready,
  input logic        done,
  input logic        bus_cs_n,
  input logic        bus_rd_n,
  input logic        bus_wr_n,
  input logic        bus_a0,
  input logic [15:0] bus_dout
);
  // R8
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));
  // R8
  stable_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!bus_rd_n || !bus_wr_n) && $past(!bus_rd_n || !bus_wr_n)) |-> ($stable(bus_a0) && $stable(bus_dout)));
  // R9
  strobe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_wr_n) |-> !bus_cs_n);
  // R10
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cs_n |-> !ready);
  // R5
  read_on_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> bus_a0);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready);
endmodule

bind regbus_seq regbus_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ready(ready), .done(done),
  .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
  .bus_a0(bus_a0), .bus_dout(bus_dout)
);

// File: tb/regbus_seq_tb.sv
`timescale 1ns/1ps
module regbus_seq_tb_top;
  localparam int CLK_PS = 5000;
  localparam int S = 2;
  localparam int A = (300000 + CLK_PS - 1) / CLK_PS;
  localparam int D = (150000 + CLK_PS - 1) / CLK_PS;

  logic clk = 0, rst_n = 0, req = 0, write = 0;
  logic [6:0] index = '0;
  logic [31:0] wdata = '0;
  logic ready, done, bus_cs_n, bus_rd_n, bus_wr_n, bus_a0, bus_doe;
  logic [31:0] rdata;
  logic [15:0] bus_dout, bus_din;

  always #2.5 clk = ~clk;

  regbus_seq #(.CLK_PS(CLK_PS), .ADDR_GAP_PS(300000), .DATA_GAP_PS(150000),
               .STROBE_CYC(S), .WIDE_LIMIT(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .index(index),
    .write(write), .wdata(wdata), .rdata(rdata), .done(done),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_a0(bus_a0), .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din));

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // peripheral model and bus monitor
  logic s, prev_s, prev_a0;
  int idle_cnt, slen, dcount, naddr;
  logic [7:0] addr_seen;
  logic [15:0] wcap [2];

  assign bus_din = (dcount == 0) ? {8'h10, addr_seen} : {8'h20, addr_seen};

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_s = 0; prev_a0 = 0; idle_cnt = 0; slen = 0; dcount = 0; naddr = 0;
      addr_seen = '0; wcap[0] = '0; wcap[1] = '0;
    end else begin
      s = !bus_rd_n || !bus_wr_n;
      if (s && !prev_s) begin
        chk(!bus_cs_n, "R9 cs low during strobe", bus_cs_n, 0);
        if (!bus_a0) begin
          chk(!bus_wr_n && bus_rd_n, "R1 address access is a write", bus_wr_n, 0);
          addr_seen = bus_dout[7:0];
          dcount = 0;
          naddr++;
        end else begin
          if (prev_a0) chk(idle_cnt == D, "R7 gap between data strobes", idle_cnt, D);
          else         chk(idle_cnt == A, "R6 gap after address strobe", idle_cnt, A);
          if (!bus_wr_n && dcount < 2) wcap[dcount] = bus_dout;
        end
        prev_a0 = bus_a0;
        slen = 0;
      end
      if (s) slen++;
      if (!s && prev_s) begin
        chk(slen == S, "R8 strobe width", slen, S);
        if (prev_a0) dcount++;
        idle_cnt = 1;
      end else if (!s) idle_cnt++;
      prev_s = s;
    end
  end

  task automatic run_txn(input bit wr, input logic [6:0] idx, input logic [31:0] wd,
                         input int hold_busy);
    int n0, n;
    bit wide;
    logic [31:0] exp_rd;
    wide = (idx < 7'h20);
    n0 = naddr;
    @(negedge clk);
    write = wr; index = idx; wdata = wd; req = 1;
    @(negedge clk);
    chk(!ready, "R10 ready low after accept", ready, 0);
    // R10: keep requesting with other inputs while busy
    for (int k = 0; k < hold_busy; k++) begin
      index = ~idx; wdata = ~wd; write = ~wr;
      @(negedge clk);
    end
    req = 0;
    n = hold_busy + 1;
    while (!done && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk(n == (wide ? 3*S + A + 2*D : 2*S + A + D) + 1, "R11 completion latency", n,
        (wide ? 3*S + A + 2*D : 2*S + A + D) + 1);
    chk(ready, "R11 ready with done", ready, 1);
    chk(naddr == n0 + 1, "R1 one address access per request", naddr - n0, 1);
    chk(addr_seen == {wr, idx}, "R2 index byte", addr_seen, {wr, idx});
    chk(dcount == (wide ? 2 : 1), "R3 data transfer count", dcount, wide ? 2 : 1);
    if (wr) begin
      chk(wcap[0] == wd[15:0], "R4 low halfword", wcap[0], wd[15:0]);
      if (wide) chk(wcap[1] == wd[31:16], "R4 high halfword", wcap[1], wd[31:16]);
    end else begin
      exp_rd = wide ? {8'h20, 1'b0, idx, 8'h10, 1'b0, idx} : {16'h0, 8'h10, 1'b0, idx};
      chk(rdata == exp_rd, "R5 read data", rdata, exp_rd);
    end
    @(negedge clk);
    chk(!done, "R11 done one cycle", done, 0);
  endtask

  // {write, index, wdata}
  localparam logic [39:0] VEC [8] = '{
    {1'b1, 7'h01, 32'hDEAD_BEEF},
    {1'b1, 7'h25, 32'h0000_C3A5},
    {1'b0, 7'h1F, 32'h0},
    {1'b0, 7'h20, 32'h0},
    {1'b1, 7'h20, 32'h1111_5A5A},
    {1'b0, 7'h03, 32'h0},
    {1'b1, 7'h1F, 32'h8765_4321},
    {1'b0, 7'h7F, 32'h0}
  };

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R12 reset state
    chk(ready, "R12 ready in reset", ready, 1);
    chk(bus_cs_n && bus_rd_n && bus_wr_n, "R12 strobes idle",
        {bus_cs_n, bus_rd_n, bus_wr_n}, 3'b111);
    chk(!done, "R12 done low", done, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(bus_cs_n, "R9 cs high while idle", bus_cs_n, 1);
    for (int i = 0; i < 8; i++)
      run_txn(VEC[i][39], VEC[i][38:32], VEC[i][31:0], 0);
    // R10 busy request held with altered inputs, wide write then narrow read
    run_txn(1'b1, 7'h0A, 32'hCAFE_F00D, 10);
    run_txn(1'b0, 7'h30, 32'h0, 12);
    // R5 narrow read after wide read clears upper half
    run_txn(1'b0, 7'h00, 32'h0, 0);
    run_txn(1'b0, 7'h2C, 32'h0, 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule